// File: doc/BRIEF.md
# Two-Level Lookahead Adder with Condition Flags

This block is a purely combinational 16-bit binary adder. It takes two operands and a carry-in and returns their sum together with carry, signed-overflow and zero flags. The adder is split into four 4-bit groups. Inside each group, a first lookahead level turns per-bit generate and propagate terms into the carry that enters every bit. It also forms a group generate and a group propagate. A second lookahead level takes those group terms and produces, as flat sums of products, the carry out of every group. The carry out of the top group is the final carry-out, so the carry flag comes straight from the second level.

Each sum bit is the bit's propagate term XOR the carry entering that bit. Overflow is the final carry XOR the carry entering the most significant bit. That second carry comes from the top group's first-level lookahead. Zero is a NOR over the finished sum. Subtraction is done outside the block: invert the subtrahend and set the carry-in to 1. The internal group carries and bit carries are brought out so the carry network can be watched directly.

Top module: `lookahead_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of `a + b + cin`, taken as unsigned values.
- R2: `c_flag` equals bit 16 of the 17-bit unsigned result of `a + b + cin`.
- R3: `grp_carry[k]` is the carry out of group k, where group k covers bits 4k+3 down to 4k. It equals bit 4k+4 of `(a mod 2^(4k+4)) + (b mod 2^(4k+4)) + cin`. `grp_carry[3]` equals `c_flag`.
- R4: `bit_carry[i]` is the carry into bit i. It equals bit i of `(a mod 2^i) + (b mod 2^i) + cin`, so `bit_carry[0]` equals `cin`.
- R5: `v_flag` is high exactly when the signed two's-complement sum overflows. That happens when `a[15]` equals `b[15]` and `sum[15]` differs from them. The same condition is `c_flag` XOR `bit_carry[15]`.
- R6: `z_flag` is high exactly when all 16 bits of `sum` are zero. This holds whatever the value of `c_flag`.
- R7: With `b` set to the bitwise inverse of a subtrahend y and `cin` = 1, `sum` equals `a - y` mod 2^16. In that case `c_flag` is 1 exactly when `a >= y` as unsigned values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| c_flag | output | 1 | Final carry-out from the second lookahead level |
| v_flag | output | 1 | Signed overflow |
| z_flag | output | 1 | High when the sum is all zeros |
| grp_carry | output | 4 | Carry out of each 4-bit group |
| bit_carry | output | 16 | Carry into each bit position |

## Verification
The block has no registers, so every output is due in the same cycle that the operands are applied, once the logic settles. The bench drives each stimulus just after a rising clock edge and samples all outputs at the following falling edge, half a period later. By then the combinational paths have settled, and no check depends on the order in which events are processed at an edge. Expected values come from a 17-bit behavioural addition and from masked partial sums in the bench. They are not taken from the lookahead structure.

// File: rtl/la_adder_pkg.sv
package la_adder_pkg;

  localparam int unsigned LA_MAX = 32;

  // Carry into position k of a lookahead span: the OR over j<k of
  // (g[j] AND p[j+1..k-1]) together with (cin AND p[0..k-1]).
  // The result is a flat sum of products with no chaining between terms.
  function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                    input logic [LA_MAX-1:0] p,
                                    input logic              cin,
                                    input int unsigned       k);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int unsigned j = 0; j < LA_MAX; j++) begin
      if (j < k) begin
        term = g[j];
        for (int unsigned m = 0; m < LA_MAX; m++) begin
          if (m > j && m < k) term = term & p[m];
        end
        acc = acc | term;
      end
    end
    term = cin;
    for (int unsigned m = 0; m < LA_MAX; m++) begin
      if (m < k) term = term & p[m];
    end
    return acc | term;
  endfunction

  // Span propagate: AND of the first k propagate terms.
  function automatic logic la_span_prop(input logic [LA_MAX-1:0] p,
                                        input int unsigned       k);
    logic acc;
    acc = 1'b1;
    for (int unsigned m = 0; m < LA_MAX; m++) begin
      if (m < k) acc = acc & p[m];
    end
    return acc;
  endfunction

endpackage

// File: rtl/la_group.sv
module la_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] gen,
  input  logic [GW-1:0] prop,
  input  logic          cin,
  output logic [GW-1:0] c_into,
  output logic          grp_gen,
  output logic          grp_prop
);
  import la_adder_pkg::*;

  logic [LA_MAX-1:0] gen_w;
  logic [LA_MAX-1:0] prop_w;

  assign gen_w  = LA_MAX'(gen);
  assign prop_w = LA_MAX'(prop);

  for (genvar i = 0; i < GW; i++) begin : g_bit
    assign c_into[i] = la_carry(gen_w, prop_w, cin, i);
  end

  assign grp_gen  = la_carry(gen_w, prop_w, 1'b0, GW);
  assign grp_prop = la_span_prop(prop_w, GW);
endmodule

// File: rtl/la_span.sv
module la_span #(
  parameter int unsigned NG = 4
) (
  input  logic [NG-1:0] grp_gen,
  input  logic [NG-1:0] grp_prop,
  input  logic          cin,
  output logic [NG-1:0] grp_cout
);
  import la_adder_pkg::*;

  logic [LA_MAX-1:0] gen_w;
  logic [LA_MAX-1:0] prop_w;

  assign gen_w  = LA_MAX'(grp_gen);
  assign prop_w = LA_MAX'(grp_prop);

  for (genvar k = 0; k < NG; k++) begin : g_grp
    assign grp_cout[k] = la_carry(gen_w, prop_w, cin, k + 1);
  end
endmodule

// File: rtl/la_flags.sv
module la_flags #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] sum,
  input  logic          c_top,
  input  logic          c_msb,
  output logic          c_flag,
  output logic          v_flag,
  output logic          z_flag
);
  assign c_flag = c_top;
  assign v_flag = c_top ^ c_msb;
  assign z_flag = ~|sum;
endmodule

// File: rtl/lookahead_adder16.sv
module lookahead_adder16 #(
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4
) (
  input  logic [GW*NG-1:0] a,
  input  logic [GW*NG-1:0] b,
  input  logic             cin,
  output logic [GW*NG-1:0] sum,
  output logic             c_flag,
  output logic             v_flag,
  output logic             z_flag,
  output logic [NG-1:0]    grp_carry,
  output logic [GW*NG-1:0] bit_carry
);
  localparam int unsigned DW = GW * NG;

  logic [DW-1:0] bit_gen;
  logic [DW-1:0] bit_prop;
  logic [NG-1:0] grp_gen;
  logic [NG-1:0] grp_prop;
  logic [NG-1:0] grp_cin;

  assign bit_gen  = a & b;
  assign bit_prop = a ^ b;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    if (k == 0) begin : g_first
      assign grp_cin[k] = cin;
    end else begin : g_rest
      assign grp_cin[k] = grp_carry[k-1];
    end

    la_group #(.GW(GW)) u_grp (
      .gen     (bit_gen[k*GW +: GW]),
      .prop    (bit_prop[k*GW +: GW]),
      .cin     (grp_cin[k]),
      .c_into  (bit_carry[k*GW +: GW]),
      .grp_gen (grp_gen[k]),
      .grp_prop(grp_prop[k])
    );
  end

  la_span #(.NG(NG)) u_span (
    .grp_gen (grp_gen),
    .grp_prop(grp_prop),
    .cin     (cin),
    .grp_cout(grp_carry)
  );

  assign sum = bit_prop ^ bit_carry;

  la_flags #(.DW(DW)) u_flags (
    .sum   (sum),
    .c_top (grp_carry[NG-1]),
    .c_msb (bit_carry[DW-1]),
    .c_flag(c_flag),
    .v_flag(v_flag),
    .z_flag(z_flag)
  );
endmodule

// File: rtl/la_adder_chk.sv
module la_adder_chk #(
  parameter int unsigned GW = 4,
  parameter int unsigned NG = 4
) (
  input logic [GW*NG-1:0] a,
  input logic [GW*NG-1:0] b,
  input logic             cin,
  input logic [GW*NG-1:0] sum,
  input logic             c_flag,
  input logic             v_flag,
  input logic             z_flag,
  input logic [NG-1:0]    grp_carry,
  input logic [GW*NG-1:0] bit_carry
);
  localparam int unsigned DW = GW * NG;

  logic [DW:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};

  always_comb begin
    a_r1_sum_value: assert (sum == full[DW-1:0])
      else $error("R1 sum mismatch");
    a_r2_carry_out: assert (c_flag == full[DW])
      else $error("R2 carry flag mismatch");
    a_r3_top_group: assert (grp_carry[NG-1] == c_flag)
      else $error("R3 top group carry differs from carry flag");
    a_r4_first_bit: assert (bit_carry[0] == cin)
      else $error("R4 carry into bit 0 differs from cin");
    a_r5_overflow: assert (v_flag == ((a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1])))
      else $error("R5 overflow flag mismatch");
    a_r6_zero: assert (z_flag == (sum == '0))
      else $error("R6 zero flag mismatch");
  end

  // R4: at every group boundary the bit carry equals the lower group's carry-out.
  for (genvar k = 1; k < NG; k++) begin : g_bnd
    always_comb begin
      a_r4_group_edge: assert (bit_carry[k*GW] == grp_carry[k-1])
        else $error("R4 boundary carry mismatch");
    end
  end
endmodule

bind lookahead_adder16 la_adder_chk #(.GW(GW), .NG(NG)) u_chk (
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .c_flag   (c_flag),
  .v_flag   (v_flag),
  .z_flag   (z_flag),
  .grp_carry(grp_carry),
  .bit_carry(bit_carry)
);

// File: tb/sim_lookahead_adder16.sv
`timescale 1ns/1ps
module sim_lookahead_adder16;
  localparam int NVEC = 12;
  localparam int NRAND = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] a, b, sum, bit_carry;
  logic        cin, c_flag, v_flag, z_flag;
  logic [3:0]  grp_carry;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  lookahead_adder16 u0 (
    .a(a), .b(b), .cin(cin), .sum(sum),
    .c_flag(c_flag), .v_flag(v_flag), .z_flag(z_flag),
    .grp_carry(grp_carry), .bit_carry(bit_carry)
  );

  // Each entry packs {a, b, cin, sum, c, v, z}.
  localparam logic [51:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0, 1'b0},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, 1'b0, 1'b0},
    {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'h0005, 16'hFFFC, 1'b1, 16'h0002, 1'b1, 1'b0, 1'b0},
    {16'h0003, 16'hFFFA, 1'b1, 16'hFFFE, 1'b0, 1'b0, 1'b0},
    {16'h8000, 16'hFFFE, 1'b1, 16'h7FFF, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  // Carries computed from masked partial sums, independent of the lookahead structure.
  task automatic check_carries();
    logic [16:0] part;
    logic [15:0] exp_bits;
    logic [3:0]  exp_grp;
    for (int i = 0; i < 16; i++) begin
      part = {1'b0, a & ((16'h1 << i) - 16'h1)} + {1'b0, b & ((16'h1 << i) - 16'h1)} + {16'h0, cin};
      exp_bits[i] = part[i];
    end
    for (int k = 0; k < 4; k++) begin
      part = {1'b0, a & 16'((17'h1 << (4*k+4)) - 17'h1)} + {1'b0, b & 16'((17'h1 << (4*k+4)) - 17'h1)} + {16'h0, cin};
      exp_grp[k] = part[4*k+4];
    end
    check("R4 bit_carry", {16'h0, bit_carry}, {16'h0, exp_bits});
    check("R3 grp_carry", {28'h0, grp_carry}, {28'h0, exp_grp});
    check("R3 top group equals c_flag", {31'h0, grp_carry[3]}, {31'h0, c_flag});
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    @(posedge clk);
    a = va; b = vb; cin = vc;
    @(negedge clk);
  endtask

  task automatic check_model();
    logic [16:0] full;
    logic        exp_v;
    full  = {1'b0, a} + {1'b0, b} + {16'h0, cin};
    exp_v = (a[15] == b[15]) && (full[15] != a[15]);
    check("R1 sum", {16'h0, sum}, {16'h0, full[15:0]});
    check("R2 c_flag", {31'h0, c_flag}, {31'h0, full[16]});
    check("R5 v_flag", {31'h0, v_flag}, {31'h0, exp_v});
    check("R6 z_flag", {31'h0, z_flag}, {31'h0, (full[15:0] == 16'h0)});
    check_carries();
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    // Idle state with zero inputs: R6 zero flag set, R2 no carry.
    check("R6 idle z_flag", {31'h0, z_flag}, 32'h1);
    check("R2 idle c_flag", {31'h0, c_flag}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][51:36], VEC[i][35:20], VEC[i][19]);
      check("R1 table sum", {16'h0, sum}, {16'h0, VEC[i][18:3]});
      check("R2 table c_flag", {31'h0, c_flag}, {31'h0, VEC[i][2]});
      check("R5 table v_flag", {31'h0, v_flag}, {31'h0, VEC[i][1]});
      check("R6 table z_flag", {31'h0, z_flag}, {31'h0, VEC[i][0]});
      check_carries();
    end

    // R4: a carry rippling through every bit position.
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R4 full propagate", {16'h0, bit_carry}, 32'h0000FFFF);
    check("R6 zero with carry", {31'h0, z_flag}, 32'h1);

    // R7: subtraction through the inverted subtrahend.
    for (int i = 0; i < 40; i++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = (i == 0) ? x : 16'($urandom);
      apply(x, ~y, 1'b1);
      check("R7 difference", {16'h0, sum}, {16'h0, 16'(x - y)});
      check("R7 no-borrow carry", {31'h0, c_flag}, {31'h0, (x >= y)});
    end

    for (int i = 0; i < NRAND; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
      check_model();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule